// File: doc/BRIEF.md
# Seeded Burst Pattern Generator and Lane Mismatch Counter

This block supports memory training loops. From a 32-bit seed it builds a pseudo-random test burst of four 32-bit phase words, which a memory path can write out. It then compares the data read back against that burst for one chosen byte lane and returns the number of differing bits. The burst comes from a right-shifting Galois LFSR that advances one step for each byte it produces.

A training controller asserts `start_i` with a seed, a lane and an accumulate flag. It drives the read-back word on `rd_data_i` while the block is running. After a fixed latency, `done_o` pulses and `err_count_o` holds the result. Two runs with different seeds, for example 42 and then 84 with the accumulate flag set on the second, give one combined score for a delay setting. The block does not access memory itself.

Top module: `burst_pattern_checker`

## Requirements
- R1: While and after reset, `done_o` is 0, `err_count_o` is 0 and `pattern_o` is all zeros.
- R2: One LFSR step takes the old bit 0, shifts the 32-bit state right by one, and, if the old bit 0 was 1, XORs the result with 0x80200003. A zero seed therefore yields an all-zero burst.
- R3: The burst is 16 bytes. Byte k (k = 0..15) is the low 8 bits of the state after step k+1 from the seed, and it sits at `pattern_o[8k+7:8k]`. Phase p occupies bits [32p+31:32p], and byte 0 of each phase is its least significant byte.
- R4: With `lane_i` = m, only bytes (1-m) and (3-m) of each phase are compared. Differences in the other two bytes of every phase have no effect on the count.
- R5: A run adds to the count the sum, over all four phases, of the popcounts of (expected byte XOR read byte) for the compared bytes. One run adds at most 64.
- R6: A start with `acc_i` = 0 clears the count before the run. A start with `acc_i` = 1 keeps the previous count, so results from successive seeds add together.
- R7: `done_o` is high for exactly one cycle, 17 clock edges after the edge that accepts `start_i`. At that point the count and the pattern are final. `rd_data_i` is sampled on that same 17th edge.
- R8: `start_i` is ignored while a run is in progress: the result, the lane used and the latency of the run in progress are unchanged, and no extra run follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| seed_i | input | 32 | LFSR seed, taken at start |
| lane_i | input | 1 | Byte lane (module) to compare, taken at start |
| acc_i | input | 1 | 1: add to previous count; 0: clear first |
| rd_data_i | input | 128 | Read-back burst, four phase words |
| pattern_o | output | 128 | Generated burst |
| err_count_o | output | 8 | Accumulated mismatch bit count |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start request that arrives in the middle of a run. It must neither reload the seed nor change the lane. It must also not queue a second run. The stimulus starts a run on lane 0 and pulses `start_i` several edges later with a different seed and lane 1. It then expects the first run's pattern, count and latency, and it watches a quiet window afterwards for a stray completion. Lane isolation is covered by injecting bit errors only in the bytes of the lane that is not selected.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_GEN, ST_CMP} run_state_e;

  function automatic logic [63:0] lfsr_taps(input int width);
    case (width)
      8:       return 64'h0000_00b8;
      16:      return 64'h0000_d008;
      24:      return 64'h00e1_0000;
      default: return 64'h8020_0003;
    endcase
  endfunction

  function automatic logic [3:0] popcnt8(input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, b[i]};
    return n;
  endfunction

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step import burst_chk_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [63:0] TAPS_FULL = lfsr_taps(WIDTH);
  localparam logic [WIDTH-1:0] TAPS = TAPS_FULL[WIDTH-1:0];

  always_comb begin
    next_o = state_i >> 1;
    if (state_i[0]) next_o = next_o ^ TAPS;
  end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen #(
  parameter int WIDTH  = 32,
  parameter int STEPS  = 16,
  localparam int STEP_W = $clog2(STEPS),
  localparam int DATA_W = STEPS * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WIDTH-1:0]  seed_i,
  input  logic              step_en_i,
  input  logic [STEP_W-1:0] step_idx_i,
  output logic [DATA_W-1:0] pattern_o
);
  logic [WIDTH-1:0]  lfsr_q, lfsr_nxt;
  logic [DATA_W-1:0] pat_q;

  lfsr_step #(.WIDTH(WIDTH)) u_step (.state_i(lfsr_q), .next_o(lfsr_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '0;
      pat_q  <= '0;
    end else if (load_i) begin
      lfsr_q <= seed_i;
      pat_q  <= '0;
    end else if (step_en_i) begin
      lfsr_q <= lfsr_nxt;
      pat_q[int'(step_idx_i)*8 +: 8] <= lfsr_nxt[7:0];
    end
  end

  assign pattern_o = pat_q;

  // R2: a zero state never leaves zero
  a_r2_zero_stuck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !load_i && lfsr_q == '0) |=> (lfsr_q == '0));
endmodule

// File: rtl/lane_mismatch.sv
module lane_mismatch import burst_chk_pkg::*; #(
  parameter int PHASES = 4,
  parameter int BPP    = 4,
  parameter int LANES  = 2,
  localparam int GROUPS = BPP / LANES,
  localparam int DATA_W = PHASES * BPP * 8,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int MAX_ERR = PHASES * GROUPS * 8,
  localparam int CNT_W = $clog2(MAX_ERR + 1)
) (
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] got_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [CNT_W-1:0]  count_o
);
  always_comb begin
    count_o = '0;
    for (int p = 0; p < PHASES; p++) begin
      for (int g = 0; g < GROUPS; g++) begin
        count_o = count_o + CNT_W'(popcnt8(
          exp_i[(p*BPP + g*LANES + LANES - 1 - int'(lane_i))*8 +: 8] ^
          got_i[(p*BPP + g*LANES + LANES - 1 - int'(lane_i))*8 +: 8]));
      end
    end
  end
endmodule

// File: rtl/burst_pattern_checker.sv
module burst_pattern_checker import burst_chk_pkg::*; #(
  parameter int WIDTH  = 32,
  parameter int PHASES = 4,
  parameter int LANES  = 2,
  localparam int BPP    = WIDTH / 8,
  localparam int STEPS  = PHASES * BPP,
  localparam int STEP_W = $clog2(STEPS),
  localparam int DATA_W = PHASES * WIDTH,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int MAX_ERR = PHASES * (BPP / LANES) * 8,
  localparam int MIS_W  = $clog2(MAX_ERR + 1),
  localparam int CNT_W  = $clog2(2 * MAX_ERR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIDTH-1:0]  seed_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] pattern_o,
  output logic [CNT_W-1:0]  err_count_o,
  output logic              done_o
);
  run_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  err_q;
  logic              done_q;
  logic [MIS_W-1:0]  mism;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  pattern_gen #(.WIDTH(WIDTH), .STEPS(STEPS)) u_gen (
    .clk_i, .rst_ni,
    .load_i    (accept),
    .seed_i    (seed_i),
    .step_en_i (state_q == ST_GEN),
    .step_idx_i(step_q),
    .pattern_o (pattern_o)
  );

  lane_mismatch #(.PHASES(PHASES), .BPP(BPP), .LANES(LANES)) u_cmp (
    .exp_i  (pattern_o),
    .got_i  (rd_data_i),
    .lane_i (lane_q),
    .count_o(mism)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      lane_q  <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          lane_q  <= lane_i;
          step_q  <= '0;
          if (!acc_i) err_q <= '0;
          state_q <= ST_GEN;
        end
        ST_GEN: begin
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(STEPS - 1)) state_q <= ST_CMP;
        end
        ST_CMP: begin
          err_q   <= err_q + CNT_W'(mism);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_count_o = err_q;
  assign done_o      = done_q;

  a_r5_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP) |-> (int'(mism) <= MAX_ERR));
  a_r6_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !acc_i) |=> (err_q == '0));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_after_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_CMP));
  a_r8_lane_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(lane_q));
endmodule

// File: tb/burst_pattern_checker_tb_top.sv
module burst_pattern_checker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] seed = '0;
  logic lane = 1'b0;
  logic acc = 1'b0;
  logic [127:0] rd_data = '0;
  logic [127:0] pattern;
  logic [7:0] err_count;
  logic done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_exp = 0;

  logic [127:0] q_pat[$];
  int q_cnt[$];
  int q_cyc[$];
  string q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_pattern_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed), .lane_i(lane),
    .acc_i(acc), .rd_data_i(rd_data), .pattern_o(pattern),
    .err_count_o(err_count), .done_o(done)
  );

  function automatic logic [127:0] ref_burst(input logic [31:0] s);
    logic [31:0] st;
    logic [127:0] b;
    st = s;
    b = '0;
    for (int k = 0; k < 16; k++) begin
      st = (st >> 1) ^ (st[0] ? 32'h8020_0003 : 32'h0);
      b[k*8 +: 8] = st[7:0];
    end
    return b;
  endfunction

  function automatic int ref_count(input logic [127:0] diff, input logic l);
    int n;
    n = 0;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 128; k++)
        if (((k / 32) == p) && ((k % 32) / 8 == 1 - int'(l) || (k % 32) / 8 == 3 - int'(l)))
          n += int'(diff[k]);
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: computes expectations, pushes them, pulses start
  task automatic run(input logic [31:0] s, input logic l, input logic a,
                     input logic [127:0] flip, input string tag, input bit busy_poke);
    logic [127:0] p;
    int e;
    p = ref_burst(s);
    e = (a ? last_exp : 0) + ref_count(flip, l);
    last_exp = e;
    @(negedge clk);
    seed = s; lane = l; acc = a; rd_data = p ^ flip; start = 1'b1;
    q_pat.push_back(p); q_cnt.push_back(e); q_cyc.push_back(cyc + 18); q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    if (busy_poke) begin
      repeat (4) @(negedge clk);
      seed = 32'hdead_beef; lane = ~l; acc = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q_cnt.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expectations on completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_cnt.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        logic [127:0] ep;
        int ec, et;
        string t;
        ep = q_pat.pop_front(); ec = q_cnt.pop_front(); et = q_cyc.pop_front(); t = q_tag.pop_front();
        check(int'(err_count) == ec, {t, " count R5"}, err_count, ec);
        check(pattern == ep, {t, " pattern R3"}, pattern[63:0], ep[63:0]);
        check(cyc == et, {t, " latency R7"}, cyc, et);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(err_count == 8'd0, "R1 count in reset", err_count, 0);
    check(pattern == '0, "R1 pattern in reset", pattern[63:0], 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && err_count == 0, "R1 after reset", err_count, 0);

    run(32'd42, 1'b0, 1'b0, '0, "R2 seed42 clean", 1'b0);
    run(32'd84, 1'b0, 1'b1, '0, "R6 seed84 acc clean", 1'b0);
    run(32'd42, 1'b0, 1'b0, 128'h0000_0000_8100_0000_0000_0000_0000_0300, "R4 lane0 errors", 1'b0);
    run(32'd84, 1'b0, 1'b1, 128'h0f00_0000_0000_0000_0000_0000_0000_0100, "R6 acc sum", 1'b0);
    run(32'd42, 1'b1, 1'b0, {4{32'hff00_ff00}}, "R4 lane1 ignores other lane", 1'b0);
    run(32'd84, 1'b1, 1'b0, {128{1'b1}}, "R5 lane1 all flipped", 1'b0);
    run(32'd0, 1'b0, 1'b0, 128'h0000_0000_0000_0000_0000_0000_ff00_0000, "R2 zero seed", 1'b0);
    run(32'hc0ff_ee01, 1'b0, 1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_ff00, "R8 busy start", 1'b1);
    repeat (25) @(negedge clk);
    check(done == 1'b0 && q_cnt.size() == 0, "R8 no extra run", done, 0);
    check(int'(err_count) == 8, "R8 count kept", err_count, 8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule